// File: doc/BRIEF.md
# Asynchronous Character Transmitter with Line Break

This block serialises bytes onto a single transmit line using an asynchronous character format. Software or an upstream engine pushes bytes into a small first-in first-out queue inside the block. The shifter removes them one at a time and frames each byte with a low start bit, eight data bits sent least significant bit first, and one or two high stop bits. A configuration input selects the number of stop bits. Every line bit lasts one period of an externally supplied bit-rate enable pulse, and the line only changes on a clock edge where that pulse is high.

A line-break input drives the line low at the next bit-rate edge. This holds even when a character is partway out. That character is thrown away. While the break is held, no transmission takes place. Bytes already queued, and any bytes written during the break, stay in the queue. When the break is released, the line returns high for a full bit period before the next queued byte starts. A separate transmit-reset strobe empties the queue and returns the shifter to idle in the same cycle, but it leaves an active break in force.

Top module: `async_tx_brk`

## Requirements
- R1: After reset the line `txd` is high, `busy` is low, `fifo_empty` is high, `fifo_full` is low and `tx_overflow` is low. With nothing queued and no break, the line stays high.
- R2: A character consists of one low start bit, then the 8 data bits least significant bit first, then the stop bit(s), which are high. Each bit lasts from one `bit_en` edge to the next. `txd` changes only on clock edges where `bit_en` is high or `tx_rst` is high.
- R3: When `two_stop` is 0 a character carries one stop bit, and when it is 1 it carries two. The next start bit can follow directly after the last stop bit.
- R4: Queued bytes are sent in the order they were written, and back to back with no idle gap between characters.
- R5: The queue holds 16 bytes. `fifo_full` is high when 16 bytes are held and `fifo_empty` is high when none are held. Both reflect a write or a removal one cycle after the edge that performed it.
- R6: A write while `fifo_full` is high is dropped. It raises `tx_overflow` for exactly the following cycle.
- R7: On the first clock edge where both `bit_en` and `brk` are high, `txd` goes low, even in the middle of a character. That character is never sent again.
- R8: While the break lasts, `txd` stays low and no byte leaves the queue. Bytes queued before or during the break are kept.
- R9: On the first `bit_en` edge with `brk` low after a break, `txd` goes high. No start bit is issued before the following `bit_en` edge.
- R10: A `tx_rst` pulse, when no break is active, empties the queue, drops any character in flight, and sets `txd` high and `busy` low at that edge.
- R11: A `tx_rst` pulse during an active break empties the queue but keeps `txd` low. The break ends only through `brk` going low.
- R12: `busy` is high from the edge that issues a start bit until the edge that ends the last stop bit. It stays high across back-to-back characters and is low while idle or in break.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle bit-rate enable marking each line bit edge |
| wr_en | input | 1 | Write strobe for the transmit queue |
| wr_data | input | 8 | Byte to queue |
| two_stop | input | 1 | 0 selects one stop bit, 1 selects two |
| brk | input | 1 | Line-break request, level sensitive |
| tx_rst | input | 1 | Transmit reset strobe: flush queue, idle shifter |
| txd | output | 1 | Serial transmit line, high when idle |
| busy | output | 1 | High while a character is on the line |
| fifo_full | output | 1 | Queue holds 16 bytes |
| fifo_empty | output | 1 | Queue holds no bytes |
| tx_overflow | output | 1 | One-cycle pulse after a dropped write |

## Verification
Each result is due a fixed number of cycles after its stimulus:
- `txd` and `busy` react one cycle after the `bit_en` or `tx_rst` edge that decides them.
- The queue flags react one cycle after the write, the pop or the flush.
- `tx_overflow` is high for exactly the cycle after the dropped write.

The bench holds a behavioural model, built on a byte queue and a bit-position integer, that it steps at the same rising edge as the design. It compares all outputs at the following falling edge, so each expected value is read exactly one register stage after its cause. The named checks in the break and reset scenarios wait for the edge on which `bit_en` was high, then sample on the falling edge that follows.

// File: rtl/atx_pkg.sv
package atx_pkg;
   typedef enum logic [1:0] {
      TX_IDLE = 2'd0,
      TX_SEND = 2'd1,
      TX_BRK  = 2'd2
   } tx_state_e;
endpackage

// File: rtl/atx_fifo.sv
module atx_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              full,
   output logic              empty,
   output logic              overflow
);
   localparam int AW = $clog2(DEPTH);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW:0]       wr_ptr, rd_ptr;
   logic [AW:0]       count;
   logic              do_wr, do_rd;

   assign count   = wr_ptr - rd_ptr;
   assign full    = (count == (AW+1)'(DEPTH));
   assign empty   = (count == '0);
   assign do_wr   = wr_en && !full && !flush;
   assign do_rd   = rd_en && !empty && !flush;
   assign rd_data = mem[rd_ptr[AW-1:0]];

   always_ff @(posedge clk) begin
      if (do_wr) mem[wr_ptr[AW-1:0]] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         overflow <= 1'b0;
      end else if (flush) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         overflow <= 1'b0;
      end else begin
         if (do_wr) wr_ptr <= wr_ptr + 1'b1;
         if (do_rd) rd_ptr <= rd_ptr + 1'b1;
         overflow <= wr_en && full;
      end
   end

   p_flags_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty));
   p_count_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !rd_en && !flush) |=> $stable(count));
   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && full && !flush) |=> (overflow && $stable(wr_ptr)));
   p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (empty && !overflow));
endmodule

// File: rtl/atx_shifter.sv
module atx_shifter
   import atx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              brk,
   input  logic              tx_rst,
   input  logic              two_stop,
   input  logic              fifo_empty,
   input  logic [DATA_W-1:0] fifo_data,
   output logic              pop,
   output logic              txd,
   output logic              busy
);
   localparam int CW        = $clog2(DATA_W + 3);
   localparam int LAST_ONE  = DATA_W + 1;
   localparam int LAST_TWO  = DATA_W + 2;

   tx_state_e         state;
   logic [CW-1:0]     pos;
   logic [CW-1:0]     last_pos;
   logic [DATA_W-1:0] shreg;
   logic              at_end;

   assign last_pos = two_stop ? CW'(LAST_TWO) : CW'(LAST_ONE);
   assign at_end   = (state == TX_IDLE) || (state == TX_SEND && pos == last_pos);
   assign pop      = bit_en && !brk && !tx_rst && !fifo_empty && at_end;
   assign busy     = (state == TX_SEND);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= TX_IDLE;
         txd   <= 1'b1;
         pos   <= '0;
         shreg <= '0;
      end else if (bit_en && brk) begin
         state <= TX_BRK;
         txd   <= 1'b0;
      end else if (tx_rst && state != TX_BRK) begin
         state <= TX_IDLE;
         txd   <= 1'b1;
      end else if (bit_en) begin
         unique case (state)
            TX_BRK: begin
               state <= TX_IDLE;
               txd   <= 1'b1;
            end
            TX_IDLE, TX_SEND: begin
               if (at_end) begin
                  if (pop) begin
                     state <= TX_SEND;
                     shreg <= fifo_data;
                     pos   <= '0;
                     txd   <= 1'b0;
                  end else begin
                     state <= TX_IDLE;
                     txd   <= 1'b1;
                  end
               end else begin
                  pos <= pos + 1'b1;
                  if (pos < CW'(DATA_W)) begin
                     txd   <= shreg[0];
                     shreg <= shreg >> 1;
                  end else begin
                     txd <= 1'b1;
                  end
               end
            end
            default: begin
               state <= TX_IDLE;
               txd   <= 1'b1;
            end
         endcase
      end
   end

   p_tick_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_en && !tx_rst) |=> $stable(txd));
   p_break_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && brk) |=> (!txd && !busy));
   p_break_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == TX_BRK && !bit_en) |=> !txd);
   p_break_nopop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == TX_BRK) |-> !pop);
   p_release_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == TX_BRK && bit_en && !brk) |=> (txd && !busy));
   p_rst_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_rst && state != TX_BRK && !(bit_en && brk)) |=> (txd && !busy));
   p_rst_keeps_brk_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (state == TX_BRK && tx_rst && !bit_en) |=> (state == TX_BRK && !txd));
   p_start_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> (busy && !txd));
endmodule

// File: rtl/async_tx_brk.sv
module async_tx_brk #(
   parameter int DATA_W     = 8,
   parameter int FIFO_DEPTH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              two_stop,
   input  logic              brk,
   input  logic              tx_rst,
   output logic              txd,
   output logic              busy,
   output logic              fifo_full,
   output logic              fifo_empty,
   output logic              tx_overflow
);
   localparam bit DEPTH_POW2 = (FIFO_DEPTH & (FIFO_DEPTH - 1)) == 0;

   generate
      if (FIFO_DEPTH < 2 || !DEPTH_POW2) begin : g_bad_depth
         $error("FIFO_DEPTH must be a power of two of at least 2");
      end
      if (DATA_W < 5 || DATA_W > 9) begin : g_bad_width
         $error("DATA_W must lie between 5 and 9");
      end
   endgenerate

   logic              pop;
   logic [DATA_W-1:0] head;

   atx_fifo #(
      .DATA_W (DATA_W),
      .DEPTH  (FIFO_DEPTH)
   ) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (tx_rst),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .rd_en    (pop),
      .rd_data  (head),
      .full     (fifo_full),
      .empty    (fifo_empty),
      .overflow (tx_overflow)
   );

   atx_shifter #(
      .DATA_W (DATA_W)
   ) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_en     (bit_en),
      .brk        (brk),
      .tx_rst     (tx_rst),
      .two_stop   (two_stop),
      .fifo_empty (fifo_empty),
      .fifo_data  (head),
      .pop        (pop),
      .txd        (txd),
      .busy       (busy)
   );
endmodule

// File: tb/async_tx_brk_tb.sv
module async_tx_brk_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_en = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       two_stop = 1'b0;
   logic       brk = 1'b0;
   logic       tx_rst = 1'b0;
   logic       txd, busy, fifo_full, fifo_empty, tx_overflow;

   int    n_checks = 0;
   int    n_errors = 0;
   int    cycles = 0;
   bit    tick_on = 1'b1;
   bit    cmp_on = 1'b0;
   int    div_cnt = 0;
   string cur_req = "R1";

   // behavioural reference state
   logic [7:0] mq[$];
   int         m_st = 0;   // 0 idle, 1 sending, 2 break
   int         m_pos = 0;
   logic [7:0] m_cur = '0;
   logic       m_txd = 1'b1;
   logic       m_ovf = 1'b0;
   int         m_last;
   bit         m_full0, m_empty0, m_pop;
   logic [7:0] m_front;

   async_tx_brk u_dut (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .wr_en(wr_en), .wr_data(wr_data),
      .two_stop(two_stop), .brk(brk), .tx_rst(tx_rst), .txd(txd), .busy(busy),
      .fifo_full(fifo_full), .fifo_empty(fifo_empty), .tx_overflow(tx_overflow)
   );

   always #2.5 clk = ~clk;

   task automatic check(input string req, input string what, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s actual=%0b expected=%0b at cycle %0d", req, what, act, exp, cycles);
      end
   endtask

   task automatic finish_run();
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   endtask

   // bit-rate enable: one cycle in four
   always @(negedge clk) begin
      if (tick_on) begin
         div_cnt <= (div_cnt == 3) ? 0 : div_cnt + 1;
         bit_en  <= (div_cnt == 3);
      end else begin
         bit_en <= 1'b0;
      end
   end

   // reference model, stepped at the same edge as the design
   always @(posedge clk) begin
      if (!rst_n) begin
         mq.delete(); m_st = 0; m_pos = 0; m_txd = 1'b1; m_ovf = 1'b0;
      end else begin
         m_last   = two_stop ? 10 : 9;
         m_full0  = (mq.size() == 16);
         m_empty0 = (mq.size() == 0);
         m_front  = m_empty0 ? 8'h00 : mq[0];
         m_pop    = bit_en && !brk && !tx_rst && !m_empty0 &&
                    (m_st == 0 || (m_st == 1 && m_pos == m_last));
         if (bit_en && brk) begin
            m_st = 2; m_txd = 1'b0;
         end else if (tx_rst && m_st != 2) begin
            m_st = 0; m_txd = 1'b1;
         end else if (bit_en) begin
            if (m_st == 2) begin
               m_st = 0; m_txd = 1'b1;
            end else if (m_st == 0 || m_pos == m_last) begin
               if (m_pop) begin
                  m_cur = m_front; m_pos = 0; m_st = 1; m_txd = 1'b0;
               end else begin
                  m_st = 0; m_txd = 1'b1;
               end
            end else begin
               m_pos++;
               m_txd = (m_pos <= 8) ? m_cur[m_pos-1] : 1'b1;
            end
         end
         if (tx_rst) begin
            mq.delete(); m_ovf = 1'b0;
         end else begin
            if (m_pop) void'(mq.pop_front());
            if (wr_en && !m_full0) mq.push_back(wr_data);
            m_ovf = wr_en && m_full0;
         end
      end
   end

   // compare on every falling edge
   always @(negedge clk) begin
      cycles++;
      if (cmp_on) begin
         check(cur_req, "txd", txd, m_txd);
         check("R12", "busy", busy, m_st == 1);
         check("R5", "fifo_full", fifo_full, mq.size() == 16);
         check("R5", "fifo_empty", fifo_empty, mq.size() == 0);
         check("R6", "tx_overflow", tx_overflow, m_ovf);
      end
      if (cycles > 150000) begin
         n_checks++; n_errors++;
         $display("FAIL watchdog expired in %s", cur_req);
         finish_run();
      end
   end

   task automatic put(input logic [7:0] b);
      @(negedge clk); wr_en = 1'b1; wr_data = b;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic wait_tick();
      do @(posedge clk); while (!bit_en);
      @(negedge clk);
   endtask

   task automatic wait_idle();
      int guard = 0;
      while ((m_st != 0 || mq.size() != 0) && guard < 5000) begin
         @(negedge clk); guard++;
      end
      repeat (12) @(negedge clk);
   endtask

   task automatic pulse_rst();
      @(negedge clk); tx_rst = 1'b1;
      @(negedge clk); tx_rst = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cur_req = "R1";
      check("R1", "txd idle", txd, 1'b1);
      check("R1", "busy idle", busy, 1'b0);
      check("R1", "empty idle", fifo_empty, 1'b1);
      check("R1", "full idle", fifo_full, 1'b0);
      check("R1", "overflow idle", tx_overflow, 1'b0);
      cmp_on = 1'b1;
      repeat (20) @(negedge clk);

      // R2: framing with one stop bit, two distinct patterns
      cur_req = "R2";
      two_stop = 1'b0;
      put(8'hA5); put(8'h3C);
      wait_idle();

      // R3: two stop bits
      cur_req = "R3";
      two_stop = 1'b1;
      put(8'h81); put(8'h7E);
      wait_idle();
      two_stop = 1'b0;

      // R4 / R5 / R6: fill, overflow, drain in order
      cur_req = "R4";
      tick_on = 1'b0;
      @(negedge clk);
      for (int i = 0; i < 16; i++) put(8'(i * 17 + 3));
      check("R5", "full after 16 writes", fifo_full, 1'b1);
      @(negedge clk); wr_en = 1'b1; wr_data = 8'hEE;
      @(negedge clk); wr_en = 1'b0;
      check("R6", "overflow pulse", tx_overflow, 1'b1);
      @(negedge clk);
      check("R6", "overflow one cycle", tx_overflow, 1'b0);
      tick_on = 1'b1;
      wait_idle();

      // R7 / R8 / R11 / R9: break mid-character
      cur_req = "R7";
      put(8'h55);
      repeat (5) wait_tick();
      @(negedge clk); brk = 1'b1;
      wait_tick();
      check("R7", "txd low after break edge", txd, 1'b0);
      check("R7", "busy low in break", busy, 1'b0);
      cur_req = "R8";
      put(8'h12); put(8'h34);
      repeat (4) wait_tick();
      check("R8", "txd held low", txd, 1'b0);
      check("R8", "queue kept in break", fifo_empty, 1'b0);
      cur_req = "R11";
      @(negedge clk); tx_rst = 1'b1;
      @(negedge clk); tx_rst = 1'b0;
      check("R11", "txd low after reset in break", txd, 1'b0);
      check("R11", "queue flushed", fifo_empty, 1'b1);
      repeat (3) wait_tick();
      check("R11", "break persists", txd, 1'b0);
      put(8'hC3);
      cur_req = "R9";
      @(negedge clk); brk = 1'b0;
      wait_tick();
      check("R9", "line high after release", txd, 1'b1);
      check("R9", "no start yet", busy, 1'b0);
      wait_tick();
      check("R9", "start after full high bit", txd, 1'b0);
      wait_idle();

      // R10: transmit reset mid-character
      cur_req = "R10";
      put(8'h00); put(8'hFF);
      repeat (4) wait_tick();
      pulse_rst();
      check("R10", "txd high after reset", txd, 1'b1);
      check("R10", "busy low after reset", busy, 1'b0);
      check("R10", "queue empty after reset", fifo_empty, 1'b1);
      repeat (30) @(negedge clk);
      check("R10", "no further character", busy, 1'b0);

      // R12 with back-to-back traffic and two stop bits
      cur_req = "R12";
      two_stop = 1'b1;
      put(8'h0F); put(8'hF0); put(8'h99);
      wait_idle();
      check("R1", "idle line at end", txd, 1'b1);
      finish_run();
   end
endmodule